// File: doc/BRIEF.md
# Keyed Indexed Configuration Port

This block is a byte-wide configuration interface that sits behind two host I/O addresses. The lower address is shared by the key port and the index port. The upper address is the data port. A host writes a register number to the index port and then reads or writes that register through the data port. The register space is locked after reset. It opens only after the enter key (0x87) has been written to the index port twice in a row, and it closes again when the exit key (0xAA) is written there.

The register space has two parts. The global part holds a device-select register and a read-only identity byte. The banked part has one copy per logical device: an activation register plus a small window of function registers. The device-select register chooses which copy the data port reaches. Every bank is exported in parallel to the attached function blocks, and bit 0 of each activation register drives a per-device enable. In a typical system the watchdog/GPIO function is wired to the bank of logical device 8.

Top module: `cfg_port_unlock`

## Requirements
- R1: A write to address 0 in the open state loads the index register, unless the byte is 0xAA. A read of address 0 returns the index register when open and 0xFF when locked.
- R2: The block opens only when 0x87 is written to address 0 in two consecutive bus writes. Any other write to either address between the two 0x87 writes restarts the sequence. `cfg_open` is high while the block is open.
- R3: Writing 0xAA to address 0 in the open state locks the block and leaves the index register unchanged.
- R4: While locked, reads of address 1 return 0xFF and writes to address 1 change no register.
- R5: Global register 0x07 is the logical-device number. It can be read and written, and it selects the bank reached through the data port.
- R6: Global register 0x20 always reads CHIP_ID (default 0x5C), and writes to it are ignored.
- R7: Register 0x30 in the selected bank is the activation byte of that device, and `ldev_active[n]` equals bit 0 of the activation byte of device n.
- R8: Registers BANK_BASE..BANK_BASE+BANK_WIN-1 (default 0xF0..0xF7) are per-device function registers. Device n, offset k appears on `ldev_regs[(n*BANK_WIN+k)*8 +: 8]`.
- R9: When the device number is NUM_LDEV or more, banked registers read 0x00 and ignore writes. Unassigned global indices also read 0x00 and ignore writes.
- R10: Reset locks the block and clears the index, the device number, every bank register and the read data.
- R11: Read data appears on `io_rdata` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 1 | 0 = key/index port, 1 = data port |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | Configuration space is unlocked |
| ldev_active | output | NUM_LDEV | Bit 0 of each device's activation byte |
| ldev_regs | output | NUM_LDEV*BANK_WIN*8 | All per-device function registers, flattened |

## Verification
The hardest states to reach are the half-unlocked state and its interruptions. A single 0x87 followed by a foreign byte, or by a data-port write, must not leave a stale half-key behind, so the stimulus first clears the sequence with a neutral write. It then interleaves 0x87 with other writes before the real double key. A second hard corner is a device number beyond the last bank, which is reached by writing an out-of-range value into register 0x07 and then trying reads and writes on the window. A behavioural model in the bench tracks the lock state, the index and every bank. It is compared on each clock against the read data, the open flag and all exported registers.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam logic [7:0] KEY_ENTER   = 8'h87;
    localparam logic [7:0] KEY_EXIT    = 8'hAA;
    localparam logic [7:0] REG_LDN     = 8'h07;
    localparam logic [7:0] REG_ID      = 8'h20;
    localparam logic [7:0] REG_ACT     = 8'h30;
    localparam logic [7:0] BYTE_LOCKED = 8'hFF;
    localparam logic [7:0] BYTE_EMPTY  = 8'h00;

    typedef enum logic [1:0] {
        LK_SHUT  = 2'd0,
        LK_ARMED = 2'd1,
        LK_OPEN  = 2'd2
    } lock_e;

    typedef struct packed {
        logic       addr;
        logic       wr;
        logic       rd;
        logic [7:0] wdata;
    } io_req_t;

endpackage

// File: rtl/cfgp_keyseq.sv
module cfgp_keyseq
    import cfgp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  io_req_t req,
    output logic    open_o,
    output logic    idx_we_o
);

    typedef struct packed {
        lock_e st;
    } key_state_t;

    key_state_t ks_d, ks_q;
    logic       key_port_wr;

    always_comb begin
        ks_d        = ks_q;
        key_port_wr = req.wr && !req.addr;
        case (ks_q.st)
            LK_SHUT: begin
                if (req.wr)
                    ks_d.st = (key_port_wr && req.wdata == KEY_ENTER) ? LK_ARMED : LK_SHUT;
            end
            LK_ARMED: begin
                if (req.wr)
                    ks_d.st = (key_port_wr && req.wdata == KEY_ENTER) ? LK_OPEN : LK_SHUT;
            end
            LK_OPEN: begin
                if (key_port_wr && req.wdata == KEY_EXIT)
                    ks_d.st = LK_SHUT;
            end
            default: ks_d.st = LK_SHUT;
        endcase
        open_o   = (ks_q.st == LK_OPEN);
        idx_we_o = open_o && key_port_wr && (req.wdata != KEY_EXIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ks_q <= '{st: LK_SHUT};
        else        ks_q <= ks_d;
    end

    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(req.wr && !req.addr && req.wdata == KEY_ENTER))
        else $error("open without enter key"); // R2

    AST_FOREIGN_WRITE_KEEPS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_o && req.wr && !(!req.addr && req.wdata == KEY_ENTER)) |=> !open_o)
        else $error("foreign write opened port"); // R2

    AST_EXIT_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && req.wr && !req.addr && req.wdata == KEY_EXIT) |=> !open_o)
        else $error("exit key did not lock"); // R3

endmodule

// File: rtl/cfgp_decode.sv
module cfgp_decode
    import cfgp_pkg::*;
#(
    parameter int         NUM_LDEV  = 16,
    parameter int         BANK_WIN  = 8,
    parameter logic [7:0] BANK_BASE = 8'hF0,
    parameter logic [7:0] CHIP_ID   = 8'h5C,
    localparam int        LDN_W     = $clog2(NUM_LDEV),
    localparam int        SLOT_W    = $clog2(NUM_LDEV * BANK_WIN)
) (
    input  logic [7:0]                         idx_i,
    input  logic [7:0]                         ldn_i,
    input  logic [NUM_LDEV-1:0][7:0]           act_i,
    input  logic [NUM_LDEV*BANK_WIN-1:0][7:0]  bank_i,
    output logic                               ldn_ok_o,
    output logic                               win_hit_o,
    output logic [LDN_W-1:0]                   ldn_idx_o,
    output logic [SLOT_W-1:0]                  slot_o,
    output logic [7:0]                         rd_byte_o
);

    localparam logic [7:0] WIN_B = 8'(BANK_WIN);
    localparam logic [7:0] NLD_B = 8'(NUM_LDEV);

    logic [7:0] rel;

    always_comb begin
        rel       = idx_i - BANK_BASE;
        win_hit_o = (rel < WIN_B);
        ldn_ok_o  = (ldn_i < NLD_B);
        ldn_idx_o = ldn_i[LDN_W-1:0];
        slot_o    = SLOT_W'(ldn_idx_o) * SLOT_W'(BANK_WIN) + SLOT_W'(rel);

        if (idx_i == REG_LDN)
            rd_byte_o = ldn_i;
        else if (idx_i == REG_ID)
            rd_byte_o = CHIP_ID;
        else if (idx_i == REG_ACT)
            rd_byte_o = ldn_ok_o ? act_i[ldn_idx_o] : BYTE_EMPTY;
        else if (win_hit_o)
            rd_byte_o = ldn_ok_o ? bank_i[slot_o] : BYTE_EMPTY;
        else
            rd_byte_o = BYTE_EMPTY;
    end

endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
    import cfgp_pkg::*;
#(
    parameter int  NUM_LDEV = 16,
    parameter int  BANK_WIN = 8,
    localparam int LDN_W    = $clog2(NUM_LDEV),
    localparam int SLOT_W   = $clog2(NUM_LDEV * BANK_WIN)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  io_req_t                            req,
    input  logic                               open_i,
    input  logic                               idx_we_i,
    input  logic                               ldn_ok_i,
    input  logic                               win_hit_i,
    input  logic [LDN_W-1:0]                   ldn_idx_i,
    input  logic [SLOT_W-1:0]                  slot_i,
    input  logic [7:0]                         rd_byte_i,
    output logic [7:0]                         idx_o,
    output logic [7:0]                         ldn_o,
    output logic [7:0]                         rdata_o,
    output logic [NUM_LDEV-1:0][7:0]           act_o,
    output logic [NUM_LDEV*BANK_WIN-1:0][7:0]  bank_o
);

    typedef struct packed {
        logic [7:0]                        idx;
        logic [7:0]                        ldn;
        logic [7:0]                        rdata;
        logic [NUM_LDEV-1:0][7:0]          act;
        logic [NUM_LDEV*BANK_WIN-1:0][7:0] bank;
    } rf_t;

    rf_t  rf_d, rf_q;
    logic data_we;

    always_comb begin
        rf_d    = rf_q;
        data_we = open_i && req.wr && req.addr;

        if (idx_we_i)
            rf_d.idx = req.wdata;

        if (data_we) begin
            if (rf_q.idx == REG_LDN)
                rf_d.ldn = req.wdata;
            else if (rf_q.idx == REG_ACT) begin
                if (ldn_ok_i) rf_d.act[ldn_idx_i] = req.wdata;
            end else if (win_hit_i && ldn_ok_i)
                rf_d.bank[slot_i] = req.wdata;
        end

        if (req.rd) begin
            if (!open_i)
                rf_d.rdata = BYTE_LOCKED;
            else
                rf_d.rdata = req.addr ? rd_byte_i : rf_q.idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign idx_o   = rf_q.idx;
    assign ldn_o   = rf_q.ldn;
    assign rdata_o = rf_q.rdata;
    assign act_o   = rf_q.act;
    assign bank_o  = rf_q.bank;

    AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !open_i |=> ($stable(ldn_o) && $stable(act_o) && $stable(bank_o)))
        else $error("register changed while locked"); // R4

    AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (req.rd && !open_i) |=> (rdata_o == BYTE_LOCKED))
        else $error("locked read not 0xFF"); // R4

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !req.rd |=> $stable(rdata_o))
        else $error("read data moved without read"); // R11

endmodule

// File: rtl/cfg_port_unlock.sv
module cfg_port_unlock
    import cfgp_pkg::*;
#(
    parameter int         NUM_LDEV  = 16,
    parameter int         BANK_WIN  = 8,
    parameter logic [7:0] BANK_BASE = 8'hF0,
    parameter logic [7:0] CHIP_ID   = 8'h5C
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            io_addr,
    input  logic                            io_wr,
    input  logic                            io_rd,
    input  logic [7:0]                      io_wdata,
    output logic [7:0]                      io_rdata,
    output logic                            cfg_open,
    output logic [NUM_LDEV-1:0]             ldev_active,
    output logic [NUM_LDEV*BANK_WIN*8-1:0]  ldev_regs
);

    localparam int LDN_W  = $clog2(NUM_LDEV);
    localparam int SLOT_W = $clog2(NUM_LDEV * BANK_WIN);

    io_req_t                           req;
    logic                              idx_we;
    logic                              ldn_ok, win_hit;
    logic [LDN_W-1:0]                  ldn_idx;
    logic [SLOT_W-1:0]                 slot;
    logic [7:0]                        rd_byte, idx, ldn;
    logic [NUM_LDEV-1:0][7:0]          act;
    logic [NUM_LDEV*BANK_WIN-1:0][7:0] bank;

    assign req = '{addr: io_addr, wr: io_wr, rd: io_rd, wdata: io_wdata};

    cfgp_keyseq u_keyseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .open_o   (cfg_open),
        .idx_we_o (idx_we)
    );

    cfgp_decode #(
        .NUM_LDEV  (NUM_LDEV),
        .BANK_WIN  (BANK_WIN),
        .BANK_BASE (BANK_BASE),
        .CHIP_ID   (CHIP_ID)
    ) u_decode (
        .idx_i     (idx),
        .ldn_i     (ldn),
        .act_i     (act),
        .bank_i    (bank),
        .ldn_ok_o  (ldn_ok),
        .win_hit_o (win_hit),
        .ldn_idx_o (ldn_idx),
        .slot_o    (slot),
        .rd_byte_o (rd_byte)
    );

    cfgp_regfile #(
        .NUM_LDEV (NUM_LDEV),
        .BANK_WIN (BANK_WIN)
    ) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .open_i    (cfg_open),
        .idx_we_i  (idx_we),
        .ldn_ok_i  (ldn_ok),
        .win_hit_i (win_hit),
        .ldn_idx_i (ldn_idx),
        .slot_i    (slot),
        .rd_byte_i (rd_byte),
        .idx_o     (idx),
        .ldn_o     (ldn),
        .rdata_o   (io_rdata),
        .act_o     (act),
        .bank_o    (bank)
    );

    for (genvar g = 0; g < NUM_LDEV; g++) begin : g_act
        assign ldev_active[g] = act[g][0];
    end

    assign ldev_regs = bank;

    AST_EXIT_KEEPS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && io_wr && !io_addr && io_wdata == KEY_EXIT) |=> $stable(idx))
        else $error("exit key altered index"); // R3

endmodule

// File: tb/test_cfg_port_unlock.sv
module test_cfg_port_unlock;

    localparam int         CLK_PERIOD = 10;
    localparam int         NLD  = 16;
    localparam int         WIN  = 8;
    localparam logic [7:0] BASE = 8'hF0;
    localparam logic [7:0] ID   = 8'h5C;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   io_addr = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]             io_wdata = 8'h00;
    logic [7:0]             io_rdata;
    logic                   cfg_open;
    logic [NLD-1:0]         ldev_active;
    logic [NLD*WIN*8-1:0]   ldev_regs;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_port_unlock #(.NUM_LDEV(NLD), .BANK_WIN(WIN), .BANK_BASE(BASE), .CHIP_ID(ID)) i_cfg_port_unlock (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
        .ldev_active(ldev_active), .ldev_regs(ldev_regs)
    );

    // Behavioural reference model
    bit         m_open, m_half;
    logic [7:0] m_idx, m_ldn, m_rdata;
    logic [7:0] m_act  [NLD];
    logic [7:0] m_bank [NLD][WIN];

    function automatic logic [7:0] m_read(input logic [7:0] i);
        int off;
        off = int'(i) - int'(BASE);
        if (i == 8'h07) return m_ldn;
        if (i == 8'h20) return ID;
        if (i == 8'h30) return (int'(m_ldn) < NLD) ? m_act[m_ldn] : 8'h00;
        if (off >= 0 && off < WIN) return (int'(m_ldn) < NLD) ? m_bank[m_ldn][off] : 8'h00;
        return 8'h00;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_open = 0; m_half = 0; m_idx = 0; m_ldn = 0; m_rdata = 0;
            for (int d = 0; d < NLD; d++) begin
                m_act[d] = 0;
                for (int k = 0; k < WIN; k++) m_bank[d][k] = 0;
            end
        end else begin
            if (io_rd) m_rdata = !m_open ? 8'hFF : (io_addr ? m_read(m_idx) : m_idx);
            if (io_wr) begin
                if (!m_open) begin
                    if (!io_addr && io_wdata == 8'h87) begin
                        if (m_half) begin m_open = 1; m_half = 0; end
                        else m_half = 1;
                    end else m_half = 0;
                end else if (!io_addr) begin
                    if (io_wdata == 8'hAA) m_open = 0;
                    else m_idx = io_wdata;
                end else begin
                    int off;
                    off = int'(m_idx) - int'(BASE);
                    if (m_idx == 8'h07) m_ldn = io_wdata;
                    else if (m_idx == 8'h30) begin
                        if (int'(m_ldn) < NLD) m_act[m_ldn] = io_wdata;
                    end else if (off >= 0 && off < WIN && int'(m_ldn) < NLD)
                        m_bank[m_ldn][off] = io_wdata;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NLD-1:0]       e_act;
            logic [NLD*WIN*8-1:0] e_regs;
            for (int d = 0; d < NLD; d++) begin
                e_act[d] = m_act[d][0];
                for (int k = 0; k < WIN; k++) e_regs[(d*WIN+k)*8 +: 8] = m_bank[d][k];
            end
            chk("R11", "model rdata", {24'b0, io_rdata}, {24'b0, m_rdata});
            chk("R2", "model open", {31'b0, cfg_open}, {31'b0, m_open});
            chk("R7", "model active", {16'b0, ldev_active}, {16'b0, e_act});
            n_checks++;
            if (ldev_regs !== e_regs) begin
                n_fail++;
                $display("FAIL R8 model regs: actual %h expected %h", ldev_regs, e_regs);
            end
        end
    end

    // Tasks start just after a falling edge
    task automatic wr(input logic a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1;
        @(negedge clk); #1;
        io_wr = 0;
    endtask

    task automatic rd(input logic a, input logic [7:0] exp, input string req);
        io_addr = a; io_rd = 1;
        @(negedge clk);
        chk(req, "read", {24'b0, io_rdata}, {24'b0, exp});
        #1 io_rd = 0;
    endtask

    task automatic summary();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        // R10 reset state
        chk("R10", "rdata", {24'b0, io_rdata}, 0);
        chk("R10", "open", {31'b0, cfg_open}, 0);
        chk("R10", "active", {16'b0, ldev_active}, 0);
        chk("R10", "regs zero", {31'b0, |ldev_regs}, 0);
        // R4 / R1 locked reads
        rd(1, 8'hFF, "R4");
        rd(0, 8'hFF, "R1");
        // R2 interrupted sequences
        wr(0, 8'h87); wr(0, 8'h55); wr(0, 8'h87);
        chk("R2", "foreign byte between keys", {31'b0, cfg_open}, 0);
        wr(0, 8'h00);
        wr(0, 8'h87); wr(1, 8'h12); wr(0, 8'h87);
        chk("R2", "data write between keys", {31'b0, cfg_open}, 0);
        wr(0, 8'h00);
        wr(0, 8'h87); wr(0, 8'h87);
        chk("R2", "double key opens", {31'b0, cfg_open}, 1);
        // R1 index readback, R5 device select
        wr(0, 8'h07);
        rd(0, 8'h07, "R1");
        rd(1, 8'h00, "R5");
        wr(1, 8'h08);
        rd(1, 8'h08, "R5");
        // R7 activation
        wr(0, 8'h30); wr(1, 8'h01);
        chk("R7", "device 8 active", {16'b0, ldev_active}, 32'h0100);
        // R8 window
        for (int k = 0; k < WIN; k++) begin
            wr(0, BASE + 8'(k)); wr(1, 8'hA0 + 8'(k));
        end
        chk("R8", "dev8 off5", {24'b0, ldev_regs[(8*WIN+5)*8 +: 8]}, 32'hA5);
        wr(0, 8'h07); wr(1, 8'h03);
        wr(0, 8'hF2); wr(1, 8'h3C);
        rd(1, 8'h3C, "R8");
        chk("R8", "dev3 off2", {24'b0, ldev_regs[(3*WIN+2)*8 +: 8]}, 32'h3C);
        wr(0, 8'h30);
        rd(1, 8'h00, "R7");
        wr(0, 8'h07); wr(1, 8'h08);
        wr(0, 8'hF2);
        rd(1, 8'hA2, "R5");
        // R6 identity
        wr(0, 8'h20);
        rd(1, ID, "R6");
        wr(1, 8'h00);
        rd(1, ID, "R6");
        // R9 out-of-range device and unassigned index
        wr(0, 8'h07); wr(1, 8'h40);
        wr(0, 8'hF1); wr(1, 8'h77);
        rd(1, 8'h00, "R9");
        chk("R9", "dev8 off1 untouched", {24'b0, ldev_regs[(8*WIN+1)*8 +: 8]}, 32'hA1);
        wr(0, 8'h30); wr(1, 8'h01);
        rd(1, 8'h00, "R9");
        chk("R9", "active untouched", {16'b0, ldev_active}, 32'h0100);
        wr(0, 8'h55); wr(1, 8'h66);
        rd(1, 8'h00, "R9");
        wr(0, 8'h07); wr(1, 8'h08);
        // R3 relock
        wr(0, 8'hF3);
        wr(0, 8'hAA);
        chk("R3", "exit locks", {31'b0, cfg_open}, 0);
        rd(0, 8'hFF, "R1");
        rd(1, 8'hFF, "R4");
        wr(1, 8'hEE);
        wr(0, 8'h87); wr(0, 8'h87);
        rd(0, 8'hF3, "R3");
        rd(1, 8'hA3, "R4");
        // R11 hold
        repeat (3) @(negedge clk);
        #1 chk("R11", "rdata held", {24'b0, io_rdata}, 32'hA3);
        // R10 second reset
        rst_n = 0;
        @(negedge clk); #1 rst_n = 1;
        @(negedge clk); #1;
        chk("R10", "open after reset", {31'b0, cfg_open}, 0);
        chk("R10", "active after reset", {16'b0, ldev_active}, 0);
        wr(0, 8'h87); wr(0, 8'h87);
        rd(0, 8'h00, "R10");
        wr(0, 8'h07);
        rd(1, 8'h00, "R10");
        @(negedge clk);
        summary();
    end

endmodule